// File: doc/BRIEF.md
# Variable-Length Instruction Step Sequencer

This block steps a small 16-bit processor through each instruction when the program memory delivers one byte per cycle. Every instruction starts with two fetch cycles. On the first, the byte on the read-data bus becomes the low half of the instruction register. On the second, the next byte becomes the high half. During the second fetch cycle the block reads an externally decoded operation class and, for multiplies, the second operand. From these it decides whether the instruction ends on that cycle or needs extra execution cycles.

Extra cycles depend on the class:

- A word-sized memory access needs two extra cycles.
- A byte-sized memory access needs one.
- A multiply needs as many cycles as the 1-based position of the highest set bit of its second operand.
- A divide always needs sixteen.

The current step is a one-hot vector that moves up by one position each cycle. A retire strobe marks the final step, and the cycle after it is always the first fetch step again. The datapath, the register file and address generation belong to the surrounding processor. The fetch-half select output tells that logic which byte address to present.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to the first fetch step (`step_o` equals 1). The instruction register clears to 0, and `retire_o` is low in that state.
- R2: Bit 0 of `step_o` is the first fetch step and bit 1 is the second. The low byte of `instr_o` captures `rd_data_i` at the end of step 0, and the high byte captures it at the end of step 1. `fetch_hi_o` is 1 exactly in step 1.
- R3: Class code 0 (ALU), and the unused codes 5, 6 and 7, take no extra cycles. `retire_o` is high during step 1.
- R4: Class codes 1 (load) and 2 (store) take 2 extra cycles when `mem_word_i` is 1 and 1 extra cycle when it is 0.
- R5: Class code 3 (multiply) takes N extra cycles, where N is the 1-based index of the most significant set bit of `mul_opnd_i` (bit 0 gives 1, bit 15 gives 16). An operand of zero takes no extra cycles.
- R6: Class code 4 (divide) takes exactly 16 extra cycles for any operand value.
- R7: `step_o` is always one-hot and moves one bit position up per cycle. Extra cycle k (counting from 1) is bit k+1. `retire_o` is high for exactly one cycle, on the last step, and the following cycle is step 0.
- R8: `op_class_i`, `mem_word_i` and `mul_opnd_i` are sampled only during step 1. Changing them during the extra cycles has no effect on the instruction length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_data_i | input | 8 | Byte from program memory |
| op_class_i | input | 3 | Decoded operation class, sampled in step 1 |
| mem_word_i | input | 1 | 1 for a 16-bit memory access, 0 for a byte access |
| mul_opnd_i | input | 16 | Second multiply operand, sampled in step 1 |
| step_o | output | 18 | One-hot current step |
| fetch_hi_o | output | 1 | 1 when the high (second) instruction byte is being fetched |
| instr_o | output | 16 | Instruction register |
| retire_o | output | 1 | Final step of the current instruction |

## Verification
Two functions can fall in the same cycle: the high-byte fetch and the retirement of an instruction that needs no extra cycles. Both happen in step 1. The bench provokes this with ALU-class instructions, unused class codes and multiplies by zero. In that cycle it checks that `fetch_hi_o` and `retire_o` are both high. On the next cycle it checks that the instruction register holds both bytes and that `step_o` is back at step 0. Long instructions are judged by counting extra cycles against an arithmetic expectation. The class and operand inputs are scrambled during those cycles to show they are ignored there.

// File: rtl/seq_pkg.sv
// Shared types for the instruction sequencer.
// Assumes the class codes are produced by an external decoder.
package seq_pkg;
    typedef enum logic [2:0] {
        CLS_ALU   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_STORE = 3'd2,
        CLS_MUL   = 3'd3,
        CLS_DIV   = 3'd4
    } op_class_e;
endpackage

// File: rtl/seq_len_calc.sv
// Computes how many extra execution cycles follow the fetch pair.
// Assumes class, size and operand are stable while step 1 is active.
module seq_len_calc
    import seq_pkg::*;
#(
    parameter int OPND_W     = 16,
    parameter int DIV_CYCLES = 16,
    parameter int LEN_W      = 5
) (
    input  logic [2:0]        op_class_i,
    input  logic              mem_word_i,
    input  logic [OPND_W-1:0] mul_opnd_i,
    output logic [LEN_W-1:0]  n_extra_o
);
    logic [LEN_W-1:0] msb_pos;

    // Find the 1-based index of the highest set operand bit (0 if none).
    always_comb begin
        msb_pos = '0;
        for (int i = 0; i < OPND_W; i++) begin
            if (mul_opnd_i[i]) msb_pos = LEN_W'(i + 1);
        end
    end

    // Select the extra cycle count for the decoded class.
    always_comb begin
        case (op_class_i)
            CLS_LOAD, CLS_STORE: n_extra_o = mem_word_i ? LEN_W'(2) : LEN_W'(1);
            CLS_MUL:             n_extra_o = msb_pos;
            CLS_DIV:             n_extra_o = LEN_W'(DIV_CYCLES);
            default:             n_extra_o = '0;
        endcase
    end
endmodule

// File: rtl/seq_step_ring.sv
// Rotating one-hot step register: shifts up each cycle, wraps to step 0 on retire.
// Assumes the retire input is asserted no later than the top step.
module seq_step_ring #(
    parameter int STEPS = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    output logic [STEPS-1:0] step_o
);
    // Advance or wrap the one-hot step vector.
    always_ff @(posedge clk) begin
        if (!rst_n)        step_o <= STEPS'(1);
        else if (retire_i) step_o <= STEPS'(1);
        else               step_o <= {step_o[STEPS-2:0], 1'b0};
    end

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(step_o));
    p_wrap_after_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> step_o[0]);
    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[0] |=> step_o[1]);
endmodule

// File: rtl/seq_instr_reg.sv
// Instruction register filled one byte per fetch step, low half first.
// Assumes exactly one of the fetch enables is high at a time.
module seq_instr_reg #(
    parameter int BYTE_W  = 8,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_lo_i,
    input  logic               load_hi_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic [INSTR_W-1:0] instr_o
);
    // Capture the fetched byte into the half selected by the step.
    always_ff @(posedge clk) begin
        if (!rst_n)         instr_o <= '0;
        else if (load_lo_i) instr_o[BYTE_W-1:0] <= rd_data_i;
        else if (load_hi_i) instr_o[INSTR_W-1:BYTE_W] <= rd_data_i;
    end

    p_lo_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo_i |=> instr_o[BYTE_W-1:0] == $past(rd_data_i));
    p_hi_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_hi_i |=> instr_o[INSTR_W-1:BYTE_W] == $past(rd_data_i));
endmodule

// File: rtl/instr_sequencer.sv
// Top of the multi-cycle instruction sequencer: two byte-fetch steps,
// then zero or more extra execution steps chosen by the operation class.
// Assumes an external decoder drives op_class_i during step 1.
module instr_sequencer
    import seq_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int INSTR_W    = 16,
    parameter int OPND_W     = 16,
    parameter int DIV_CYCLES = 16,
    localparam int MAX_EXEC  = (DIV_CYCLES > OPND_W) ? DIV_CYCLES : OPND_W,
    localparam int STEPS     = MAX_EXEC + 2,
    localparam int LEN_W     = $clog2(MAX_EXEC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  rd_data_i,
    input  logic [2:0]         op_class_i,
    input  logic               mem_word_i,
    input  logic [OPND_W-1:0]  mul_opnd_i,
    output logic [STEPS-1:0]   step_o,
    output logic               fetch_hi_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic               retire_o
);
    logic [LEN_W-1:0] n_extra;
    logic [LEN_W-1:0] cnt_q;
    logic             in_exec;

    seq_len_calc #(.OPND_W(OPND_W), .DIV_CYCLES(DIV_CYCLES), .LEN_W(LEN_W)) i_len (
        .op_class_i (op_class_i),
        .mem_word_i (mem_word_i),
        .mul_opnd_i (mul_opnd_i),
        .n_extra_o  (n_extra)
    );

    seq_step_ring #(.STEPS(STEPS)) i_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire_i (retire_o),
        .step_o   (step_o)
    );

    seq_instr_reg #(.BYTE_W(BYTE_W), .INSTR_W(INSTR_W)) i_ir (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lo_i (step_o[0]),
        .load_hi_i (step_o[1]),
        .rd_data_i (rd_data_i),
        .instr_o   (instr_o)
    );

    // Flag the execution steps that follow the fetch pair.
    always_comb in_exec = !step_o[0] && !step_o[1];

    // Latch the remaining-cycle count at step 1, count it down in execution.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (step_o[1])                 cnt_q <= n_extra;
        else if (in_exec && cnt_q != '0)    cnt_q <= cnt_q - LEN_W'(1);
    end

    // Drive the fetch-half select and the final-step strobe.
    always_comb begin
        fetch_hi_o = step_o[1];
        retire_o   = (step_o[1] && n_extra == '0) || (in_exec && cnt_q == LEN_W'(1));
    end

    p_exec_count_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec |-> cnt_q != '0);
    p_no_ring_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[STEPS-1] |-> retire_o);
    p_no_retire_on_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o[0] |-> !retire_o);
    p_count_holds_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && !retire_o) |=> cnt_q == $past(cnt_q) - LEN_W'(1));
endmodule

// File: tb/test_instr_sequencer.sv
module test_instr_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_data = '0;
    logic [2:0]  op_class = '0;
    logic        mem_word = 1'b0;
    logic [15:0] mul_opnd = '0;
    logic [17:0] step;
    logic        fetch_hi;
    logic [15:0] instr;
    logic        retire;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    instr_sequencer i_instr_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_data_i  (rd_data),
        .op_class_i (op_class),
        .mem_word_i (mem_word),
        .mul_opnd_i (mul_opnd),
        .step_o     (step),
        .fetch_hi_o (fetch_hi),
        .instr_o    (instr),
        .retire_o   (retire)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected extra cycles, from the requirements.
    function automatic int exp_len(input logic [2:0] c, input logic w, input logic [15:0] op);
        int n;
        n = 0;
        case (c)
            3'd1, 3'd2: n = w ? 2 : 1;
            3'd3: for (int i = 0; i < 16; i++) if (op[i]) n = i + 1;
            3'd4: n = 16;
            default: n = 0;
        endcase
        return n;
    endfunction

    // Run one instruction; called just after a negedge with step 0 active.
    task automatic run_instr(input logic [2:0] c, input logic w, input logic [15:0] op,
                             input logic [7:0] lo, input logic [7:0] hi);
        int n;
        n = exp_len(c, w, op);
        chk("R2 step0", step, 18'd1);
        chk("R2 fetch_hi low in step0", fetch_hi, 1'b0);
        rd_data = lo;
        op_class = 3'd4; mul_opnd = 16'hFFFF;
        @(negedge clk);
        rd_data = hi; op_class = c; mem_word = w; mul_opnd = op;
        #1;
        chk("R2 step1", step, 18'd2);
        chk("R2 fetch_hi in step1", fetch_hi, 1'b1);
        chk("R3 R5 retire at step1", retire, (n == 0));
        @(negedge clk);
        // Scramble sampled inputs during execution (R8).
        op_class = 3'd0; mul_opnd = 16'h0000; mem_word = ~w; rd_data = 8'h5A;
        #1;
        chk("R2 instr captured", instr, {hi, lo});
        for (int k = 1; k <= n; k++) begin
            chk("R7 step position", step, 18'(1) << (k + 1));
            chk("R4 R5 R6 R8 retire timing", retire, (k == n));
            @(negedge clk);
            #1;
        end
        chk("R7 back to step0", step, 18'd1);
        chk("R7 no retire in step0", retire, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset step", step, 18'd1);
        chk("R1 reset instr", instr, 16'h0);
        chk("R1 reset retire", retire, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R3: ALU and unused classes
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 5) run_instr(3'(c), 1'b0, 16'h1234, 8'(c * 17), 8'(~c));
        end
        // R4: memory accesses
        run_instr(3'd1, 1'b1, 16'h0, 8'hA1, 8'hB2);
        run_instr(3'd1, 1'b0, 16'h0, 8'hC3, 8'hD4);
        run_instr(3'd2, 1'b1, 16'h0, 8'hE5, 8'hF6);
        run_instr(3'd2, 1'b0, 16'h0, 8'h07, 8'h18);
        // R5: multiply, zero operand and every msb position with varied lower bits
        run_instr(3'd3, 1'b0, 16'h0000, 8'h11, 8'h22);
        for (int b = 0; b < 16; b++) begin
            run_instr(3'd3, 1'b0, 16'(1) << b, 8'(b), 8'h30);
            run_instr(3'd3, 1'b1, (16'(1) << b) | ((16'(1) << b) - 16'd1), 8'(b + 64), 8'h31);
            run_instr(3'd3, 1'b0, (16'(1) << b) | 16'd1, 8'(b + 128), 8'h32);
        end
        // R6: divide, operand-independent
        run_instr(3'd4, 1'b0, 16'h0000, 8'h40, 8'h41);
        run_instr(3'd4, 1'b1, 16'hFFFF, 8'h42, 8'h43);
        run_instr(3'd4, 1'b0, 16'h0001, 8'h44, 8'h45);
        // R1: reset in mid-execution
        run_instr(3'd1, 1'b1, 16'h0, 8'h99, 8'h88);
        rd_data = 8'h77;
        @(negedge clk);
        op_class = 3'd4; rd_data = 8'h66;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 mid reset step", step, 18'd1);
        chk("R1 mid reset instr", instr, 16'h0);
        rst_n = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule